// File: doc/BRIEF.md
# Dual-Channel Pattern Fill Engine

The block fills byte-addressed memory ranges with a repeating pattern. It has two independent channels. A configuration write to a channel gives it a start address, an exclusive end address, a 32-bit fill value, a pattern-width select and a trigger bit. A triggered channel then issues pattern-sized writes over a single shared write port until the range is covered. Each write carries byte enables, and the port uses a request/ready handshake.

The pattern can be 16 bits, 24 bits or 32 bits wide. In 24-bit mode the three bytes are three separate colour components. When a channel runs out of work it drops its busy flag and raises its done flag. It also pulses its own interrupt line for one cycle, but only if its start address was nonzero. A zero start address is treated as a null request: nothing is written, but the channel still completes. When both channels have writes pending, channel 0 always wins the port.

Top module: `fill_engine`

## Requirements
- R1: After reset, `ch_busy`, `ch_done`, `ch_irq` and `mem_req` are all zero.
- R2: A `cfg_wr` with `cfg_trig`=1 to an idle channel loads its configuration. From the next cycle that channel's busy bit is 1 and its done bit is 0. A `cfg_wr` with `cfg_trig`=0 has no effect.
- R3: With `cfg_mode`=00 (16-bit), each write has `mem_be`=0011. Lane 0 carries value[7:0] and lane 1 carries value[15:8] (little-endian), and lanes 2–3 carry zero. The address steps by 2, and a write is issued for every address below end.
- R4: With `cfg_mode[0]`=1, whatever `cfg_mode[1]` is (24-bit), each write has `mem_be`=0111. Lane 0 carries R=value[7:0], lane 1 carries G=value[15:8], lane 2 carries B=value[23:16], and lane 3 carries zero. The address steps by 3, and a write is issued for every address below end.
- R5: With `cfg_mode`=10 (32-bit), each write has `mem_be`=1111 and `mem_data`=value. The address steps by 4, and exactly floor((end−start)/4) words are written. If end is not greater than start, nothing is written.
- R6: A trigger with start address 0 writes nothing. The channel still completes: busy clears, done sets, and no interrupt is raised.
- R7: When a channel with a nonzero start completes, its busy bit clears and its done bit sets. Its `ch_irq` bit is high for exactly one cycle. This also happens when the range is empty.
- R8: A trigger write to a busy channel is ignored. The running fill continues with its original configuration.
- R9: While both channels have writes pending, channel 0's writes go first. The one exception is a request already presented and stalled, which completes first.
- R10: While `mem_req`=1 and `mem_rdy`=0, the next cycle presents the same request (address, data, byte enables).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Channel addressed by the write |
| cfg_trig | input | 1 | Trigger bit of the write |
| cfg_start | input | AW | Start byte address |
| cfg_end | input | AW | Exclusive end byte address |
| cfg_value | input | 32 | Fill value |
| cfg_mode | input | 2 | Bit 0: 24-bit, bit 1: 32-bit, neither: 16-bit |
| mem_req | output | 1 | Write request valid |
| mem_addr | output | AW | Address of the write's first byte (lane 0) |
| mem_data | output | 32 | Byte lane k goes to mem_addr+k |
| mem_be | output | 4 | Byte enables per lane |
| mem_rdy | input | 1 | Write accepted this cycle when high with mem_req |
| ch_busy | output | 2 | Channel fill in progress |
| ch_done | output | 2 | Channel finished flag |
| ch_irq | output | 2 | One-cycle completion interrupt per channel |

## Verification
A corrupted address register or step size shows up at the port on the very next accepted write, as a wrong address or a write past end. A wrong width decode shows up on the first write, as a byte-enable or lane mismatch. Under randomised ready, a lost arbitration lock or priority error reorders writes, which the in-order scoreboard catches at the first misplaced beat. Faults in completion logic, such as a missing or doubled interrupt or a stale done flag, surface one cycle after the last write.

// File: rtl/fill_pkg.sv
package fill_pkg;
    localparam int NCH = 2;
    localparam int DW  = 32;
    localparam int BEW = DW / 8;

    typedef enum logic [1:0] {PW16, PW24, PW32} pat_w_t;

    function automatic pat_w_t mode_to_width(input logic [1:0] m);
        if (m[0])      return PW24;
        else if (m[1]) return PW32;
        else           return PW16;
    endfunction

    function automatic logic [2:0] pat_step(input pat_w_t w);
        case (w)
            PW24:    return 3'd3;
            PW32:    return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [BEW-1:0] pat_be(input pat_w_t w);
        case (w)
            PW24:    return 4'b0111;
            PW32:    return 4'b1111;
            default: return 4'b0011;
        endcase
    endfunction

    function automatic logic [DW-1:0] pat_data(input pat_w_t w, input logic [DW-1:0] v);
        case (w)
            PW24:    return {8'h00, v[23:0]};
            PW32:    return v;
            default: return {16'h0000, v[15:0]};
        endcase
    endfunction
endpackage

// File: rtl/fill_chan.sv
module fill_chan
    import fill_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_trig,
    input  logic [AW-1:0]      cfg_start,
    input  logic [AW-1:0]      cfg_end,
    input  logic [DW-1:0]      cfg_value,
    input  logic [1:0]         cfg_mode,
    input  logic               take,
    output logic               want,
    output logic [AW-1:0]      beat_addr,
    output logic [DW-1:0]      beat_data,
    output logic [BEW-1:0]     beat_be,
    output logic               busy,
    output logic               fin,
    output logic               irq
);
    logic [AW:0]   cur_q;
    logic [AW-1:0] end_q;
    logic [DW-1:0] val_q;
    pat_w_t        pw_q;
    logic          nz_q;
    logic          fits;

    always_comb begin
        if (pw_q == PW32) fits = (cur_q + (AW+1)'(4)) <= {1'b0, end_q};
        else              fits = cur_q < {1'b0, end_q};
    end

    assign want      = busy && nz_q && fits;
    assign beat_addr = cur_q[AW-1:0];
    assign beat_data = pat_data(pw_q, val_q);
    assign beat_be   = pat_be(pw_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            fin   <= 1'b0;
            irq   <= 1'b0;
            cur_q <= '0;
            end_q <= '0;
            val_q <= '0;
            pw_q  <= PW16;
            nz_q  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!busy && cfg_wr && cfg_trig) begin
                busy  <= 1'b1;
                fin   <= 1'b0;
                cur_q <= {1'b0, cfg_start};
                end_q <= cfg_end;
                val_q <= cfg_value;
                pw_q  <= mode_to_width(cfg_mode);
                nz_q  <= (cfg_start != '0);
            end else if (busy && !want) begin
                busy <= 1'b0;
                fin  <= 1'b1;
                irq  <= nz_q;
            end else if (take) begin
                cur_q <= cur_q + (AW+1)'(pat_step(pw_q));
            end
        end
    end
endmodule

// File: rtl/fill_arb.sv
module fill_arb
    import fill_pkg::*;
#(
    parameter int AW = 16,
    parameter int N  = NCH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       want,
    input  logic [AW-1:0]      in_addr [N],
    input  logic [DW-1:0]      in_data [N],
    input  logic [BEW-1:0]     in_be   [N],
    input  logic               mem_rdy,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_data,
    output logic [BEW-1:0]     mem_be,
    output logic [N-1:0]       take
);
    localparam int SW = (N > 1) ? $clog2(N) : 1;

    logic [SW-1:0] sel, held_q, pick;
    logic          stall_q, found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (want[i] && !found) begin
                pick  = SW'(i);
                found = 1'b1;
            end
        end
        sel = stall_q ? held_q : pick;
    end

    assign mem_req  = want[sel];
    assign mem_addr = in_addr[sel];
    assign mem_data = in_data[sel];
    assign mem_be   = in_be[sel];

    generate
        for (genvar g = 0; g < N; g++) begin : g_take
            assign take[g] = (sel == SW'(g)) && mem_req && mem_rdy;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            stall_q <= 1'b0;
        end else begin
            held_q  <= sel;
            stall_q <= mem_req && !mem_rdy;
        end
    end
endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic               cfg_trig,
    input  logic [AW-1:0]      cfg_start,
    input  logic [AW-1:0]      cfg_end,
    input  logic [31:0]        cfg_value,
    input  logic [1:0]         cfg_mode,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    output logic [31:0]        mem_data,
    output logic [3:0]         mem_be,
    input  logic               mem_rdy,
    output logic [1:0]         ch_busy,
    output logic [1:0]         ch_done,
    output logic [1:0]         ch_irq
);
    logic [NCH-1:0] want, take;
    logic [AW-1:0]  b_addr [NCH];
    logic [DW-1:0]  b_data [NCH];
    logic [BEW-1:0] b_be   [NCH];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            fill_chan #(.AW(AW)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .cfg_wr    (cfg_wr && (cfg_sel == 1'(c))),
                .cfg_trig  (cfg_trig),
                .cfg_start (cfg_start),
                .cfg_end   (cfg_end),
                .cfg_value (cfg_value),
                .cfg_mode  (cfg_mode),
                .take      (take[c]),
                .want      (want[c]),
                .beat_addr (b_addr[c]),
                .beat_data (b_data[c]),
                .beat_be   (b_be[c]),
                .busy      (ch_busy[c]),
                .fin       (ch_done[c]),
                .irq       (ch_irq[c])
            );
        end
    endgenerate

    fill_arb #(.AW(AW), .N(NCH)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .want     (want),
        .in_addr  (b_addr),
        .in_data  (b_data),
        .in_be    (b_be),
        .mem_rdy  (mem_rdy),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_be   (mem_be),
        .take     (take)
    );
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_data,
    input logic [3:0]    mem_be,
    input logic          mem_rdy,
    input logic [1:0]    ch_busy,
    input logic [1:0]    ch_done,
    input logic [1:0]    ch_irq
);
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ch_busy == 2'b00) |-> !mem_req);

    a_r3_be_shape: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be == 4'b0011 || mem_be == 4'b0111 || mem_be == 4'b1111));

    generate
        for (genvar c = 0; c < 2; c++) begin : g_c
            a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
                ch_irq[c] |=> !ch_irq[c]);
            a_r7_irq_with_done: assert property (@(posedge clk) disable iff (rst)
                ch_irq[c] |-> (ch_done[c] && !ch_busy[c]));
            a_r2_busy_clears_done: assert property (@(posedge clk) disable iff (rst)
                $rose(ch_busy[c]) |-> !ch_done[c]);
        end
    endgenerate
endmodule

bind fill_engine fill_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_be   (mem_be),
    .mem_rdy  (mem_rdy),
    .ch_busy  (ch_busy),
    .ch_done  (ch_done),
    .ch_irq   (ch_irq)
);

// File: tb/fill_engine_tb.sv
module fill_engine_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_sel = 1'b0, cfg_trig = 1'b0;
    logic [AW-1:0] cfg_start = '0, cfg_end = '0;
    logic [31:0]   cfg_value = '0;
    logic [1:0]    cfg_mode = '0;
    logic          mem_req, mem_rdy = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_data;
    logic [3:0]    mem_be;
    logic [1:0]    ch_busy, ch_done, ch_irq;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [3:0]    be;
        string         tag;
    } beat_t;

    beat_t exp_q[$];
    int total = 0, bad = 0;
    int irq_cnt [2] = '{0, 0};
    logic hold_rdy = 1'b1;
    logic [7:0] lfsr = 8'hA5;
    bit finished = 0;

    always #2 clk = ~clk;

    fill_engine #(.AW(AW)) u_dut (.*);

    always @(posedge clk) begin
        #1;
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rdy <= hold_rdy ? 1'b0 : (lfsr[0] | lfsr[2]);
    end

    task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    // Monitor: compare each accepted write with the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 2; c++) if (ch_irq[c]) irq_cnt[c]++;
            if (mem_req && mem_rdy) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected write addr", {48'h0, mem_addr}, 0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, {e.tag, " addr"}, {48'h0, mem_addr}, {48'h0, e.addr});
                    check(mem_be == e.be, {e.tag, " be"}, {60'h0, mem_be}, {60'h0, e.be});
                    check(mem_data == e.data, {e.tag, " data"}, {32'h0, mem_data}, {32'h0, e.data});
                end
            end
        end
    end

    // Driver: push the expected writes for a fill
    task automatic push_fill(input logic [AW-1:0] s, input logic [AW-1:0] e,
                             input logic [31:0] v, input logic [1:0] m, input string tag);
        int a, step;
        beat_t b;
        if (s == 0) return;
        a = s;
        if (m[0]) begin step = 3; b.be = 4'b0111; b.data = {8'h00, v[23:0]}; end
        else if (m[1]) begin step = 4; b.be = 4'b1111; b.data = v; end
        else begin step = 2; b.be = 4'b0011; b.data = {16'h0, v[15:0]}; end
        b.tag = tag;
        while ((step == 4) ? (a + 4 <= int'(e)) : (a < int'(e))) begin
            b.addr = AW'(a);
            exp_q.push_back(b);
            a += step;
        end
    endtask

    task automatic trigger(input logic ch, input logic tr, input logic [AW-1:0] s,
                           input logic [AW-1:0] e, input logic [31:0] v, input logic [1:0] m);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = ch; cfg_trig = tr;
        cfg_start = s; cfg_end = e; cfg_value = v; cfg_mode = m;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_trig = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        @(negedge clk);
        while (ch_busy != 2'b00 && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
        check(ch_busy == 2'b00, {tag, " busy cleared"}, {62'h0, ch_busy}, 0);
        check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    endtask

    task automatic run(input logic ch, input logic [AW-1:0] s, input logic [AW-1:0] e,
                       input logic [31:0] v, input logic [1:0] m, input string tag);
        push_fill(s, e, v, m, tag);
        trigger(ch, 1'b1, s, e, v, m);
        wait_idle(tag);
        check(ch_done[ch] == 1'b1, {tag, " done set"}, {63'h0, ch_done[ch]}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ch_busy == 0 && ch_done == 0 && ch_irq == 0 && mem_req == 0, "R1 reset outputs",
              {56'h0, ch_busy, ch_done, ch_irq, 1'b0, mem_req}, 0);
        hold_rdy = 1'b0;

        // R2: write with trigger 0 is ignored
        trigger(1'b0, 1'b0, 16'h0900, 16'h0910, 32'h1, 2'b00);
        @(negedge clk);
        check(ch_busy == 0 && mem_req == 0, "R2 no-trigger write ignored", {62'h0, ch_busy}, 0);

        run(1'b0, 16'h0200, 16'h0205, 32'hDEADA1B2, 2'b00, "R3 16-bit");
        check(irq_cnt[0] == 1, "R7 ch0 irq once", irq_cnt[0], 1);
        run(1'b1, 16'h0300, 16'h0307, 32'hFF112233, 2'b01, "R4 24-bit");
        check(irq_cnt[1] == 1, "R7 ch1 irq once", irq_cnt[1], 1);
        run(1'b0, 16'h0310, 16'h0316, 32'h00ABCDEF, 2'b11, "R4 24-bit mode11");
        run(1'b1, 16'h0400, 16'h040B, 32'hCAFEF00D, 2'b10, "R5 32-bit");
        run(1'b0, 16'h0100, 16'h0103, 32'h12345678, 2'b10, "R5 32-bit empty");
        check(irq_cnt[0] == 3, "R7 irq on empty range", irq_cnt[0], 3);
        run(1'b1, 16'h0000, 16'h0040, 32'h55555555, 2'b00, "R6 null start");
        check(irq_cnt[1] == 2, "R6 no irq for null start", irq_cnt[1], 2);

        // R8 retrigger while busy is ignored; R2 done cleared on start
        hold_rdy = 1'b1;
        push_fill(16'h0500, 16'h0508, 32'h00001234, 2'b00, "R8 busy retrigger");
        trigger(1'b0, 1'b1, 16'h0500, 16'h0508, 32'h00001234, 2'b00);
        @(negedge clk);
        check(ch_busy[0] == 1'b1, "R2 busy after trigger", {63'h0, ch_busy[0]}, 1);
        check(ch_done[0] == 1'b0, "R2 done cleared by trigger", {63'h0, ch_done[0]}, 0);
        trigger(1'b0, 1'b1, 16'h0600, 16'h0640, 32'h0000FFFF, 2'b10);
        repeat (3) @(posedge clk);
        #1 hold_rdy = 1'b0;
        wait_idle("R8 busy retrigger");

        // R9 priority with R10 stalls
        hold_rdy = 1'b1;
        push_fill(16'h0700, 16'h0710, 32'h0A0B0C0D, 2'b10, "R9 ch0 first");
        push_fill(16'h0800, 16'h0806, 32'h00007788, 2'b00, "R9 ch1 second");
        trigger(1'b0, 1'b1, 16'h0700, 16'h0710, 32'h0A0B0C0D, 2'b10);
        trigger(1'b1, 1'b1, 16'h0800, 16'h0806, 32'h00007788, 2'b00);
        repeat (2) @(posedge clk);
        #1 hold_rdy = 1'b0;
        wait_idle("R9 R10 priority under stall");
        check(irq_cnt[0] == 5 && irq_cnt[1] == 3, "R7 irq totals", {irq_cnt[0][31:0], irq_cnt[1][31:0]}, {32'd5, 32'd3});

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule